// File: doc/BRIEF.md
# Three-Channel Programmable Timer

This block holds three independent 16-bit up-counters that share one register access port. Each channel keeps a live count, a compare value and a control word. On every active tick a channel's count advances by one. The tick can be the core clock, a strobe from video timing logic, or a divided core clock; which of these are available depends on the channel. When the count meets the compare value, or reaches the all-ones value, the channel latches sticky status flags. It can fold back to zero at the compare value, and it can raise a one-cycle interrupt pulse on its own output line.

Software programs a channel by writing the compare value, then the control word. Writing the control word restarts the count from zero and re-arms the interrupt. Software polls or acknowledges events by reading the control word. That read returns the event flags and clears the compare and all-ones flags. The interrupt controller, the address decoding and the video timing logic that produces the external strobes sit outside this block.

Top module: `tmr_unit`

## Requirements
- R1: A count write stores the low 16 bits of `reg_wdata`. A read of the count returns the live value, with no added latency.
- R2: With control bit 3 set, a tick that would make the count equal the compare value makes it 0 instead.
- R3: With control bit 3 clear, the count runs past the compare value up to 0xFFFF. The next tick wraps it to 0.
- R4: Control bit 4 enables an interrupt when the compare value is reached. Control bit 5 enables an interrupt when 0xFFFF is reached. With neither bit set, no pulse occurs, although the status flags still update.
- R5: With control bit 6 set, every enabled event pulses. With bit 6 clear, only the first enabled event after a control-word write pulses.
- R6: Readback bit 11 is set when the compare value is reached. Readback bit 12 is set when 0xFFFF is reached. A control-word read returns the flags and then clears both bits; an event in the same cycle wins over the clear.
- R7: Readback bit 10 is set by either event. Reads do not clear it; only a control-word write does.
- R8: A control-word write stores bits 9..0, sets the count to 0 and clears all three flags.
- R9: A compare-value write leaves the count unchanged.
- R10: On channel 0, control bit 8 picks the pixel strobe `pix_tick` as the tick source. On channel 1, bit 8 picks the line strobe `hsync_tick`. With bit 8 clear, channels 0 and 1 tick every clock. Each strobe affects only its own channel.
- R11: On channel 2, control bit 9 picks one tick per 8 clocks, and control bit 0 stops the count.
- R12: Channel k pulses `irq_out[k]` for one cycle, in the cycle after the tick that causes the event. A compare event and an all-ones event on the same tick give a single pulse.
- R13: `reg_sel` chooses the register: 0 for count, 1 for control word, 2 for compare value. Select 3 and channel index 3 read as 0. Control readback bits 15..13 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| pix_tick | input | 1 | Pixel-rate tick strobe for channel 0 |
| hsync_tick | input | 1 | Line-rate tick strobe for channel 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears the event flags on a control-word read |
| reg_chan | input | 2 | Channel index |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Write data; the upper bits are dropped |
| reg_rdata | output | 16 | Read data for the selected register, combinational |
| irq_out | output | 3 | One interrupt pulse line per channel |

## Verification
The channel assertions check these rules on every cycle:
- a control-word write zeroes the count;
- a compare-value write does not move a count that is not ticking;
- the stop bit freezes channel 2;
- a fold at the compare value lands on zero;
- a one-shot channel that has already fired stays quiet;
- a flag read with no event present clears the flags.

Some properties need the bench's scenarios:
- the pulse counts across sweeps of compare value, strobe count and repeat mode;
- the exact readback words;
- the one-in-eight rate;
- the separation of the two video strobes between channels;
- the merged pulse when both events fall on one tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int CTL_W  = 10;
  localparam int BUS_W  = 32;
  localparam int N_CH   = 3;
  localparam int PRE_DIV = 8;

  // control bit positions
  localparam int B_HALT    = 0;
  localparam int B_FOLD    = 3;
  localparam int B_IRQ_CMP = 4;
  localparam int B_IRQ_TOP = 5;
  localparam int B_REPEAT  = 6;
  localparam int B_EXT     = 8;
  localparam int B_DIV     = 9;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CTL_W-1:0] ctl_t;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_CTL    = 2'd1,
    SEL_CMP    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic cnt_t trunc_word(input logic [BUS_W-1:0] w);
    return w[CNT_W-1:0];
  endfunction

  function automatic cnt_t step_count(input cnt_t cur, input cnt_t cmp, input logic fold);
    cnt_t inc;
    inc = cur + cnt_t'(1);
    return (fold && inc == cmp) ? '0 : inc;
  endfunction

  function automatic logic [15:0] pack_ctl(input ctl_t ctl, input logic any_ev,
                                           input logic cmp_ev, input logic top_ev);
    return {3'b000, top_ev, cmp_ev, any_ev, ctl};
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  input  logic div_tick,
  input  logic count_wr,
  input  logic ctl_wr,
  input  logic cmp_wr,
  input  logic ctl_rd,
  input  cnt_t wdata,
  output cnt_t count_o,
  output cnt_t cmp_o,
  output logic [15:0] ctl_o,
  output logic irq_o
);
  cnt_t count_q, cmp_q;
  ctl_t ctl_q;
  logic fired_q, st_cmp_q, st_top_q, st_any_q, irq_q;

  // named internal events
  logic tick_en, blk, hit_cmp, hit_top, want_irq, fire_ok;
  cnt_t inc;

  generate
    if (CH_IDX == 2) begin : g_src_div
      assign tick_en = !ctl_q[B_HALT] && (ctl_q[B_DIV] ? div_tick : 1'b1);
    end else begin : g_src_ext
      assign tick_en = ctl_q[B_EXT] ? ext_tick : 1'b1;
    end
  endgenerate

  assign blk      = count_wr | ctl_wr;
  assign inc      = count_q + cnt_t'(1);
  assign hit_cmp  = tick_en && !blk && (inc == cmp_q);
  assign hit_top  = tick_en && !blk && (inc == '1);
  assign want_irq = (hit_cmp && ctl_q[B_IRQ_CMP]) || (hit_top && ctl_q[B_IRQ_TOP]);
  assign fire_ok  = want_irq && (ctl_q[B_REPEAT] || !fired_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      cmp_q    <= '0;
      ctl_q    <= '0;
      fired_q  <= 1'b0;
      st_cmp_q <= 1'b0;
      st_top_q <= 1'b0;
      st_any_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= fire_ok;
      if (ctl_wr) begin
        ctl_q    <= wdata[CTL_W-1:0];
        count_q  <= '0;
        fired_q  <= 1'b0;
        st_cmp_q <= 1'b0;
        st_top_q <= 1'b0;
        st_any_q <= 1'b0;
      end else begin
        if (count_wr)     count_q <= wdata;
        else if (tick_en) count_q <= step_count(count_q, cmp_q, ctl_q[B_FOLD]);
        if (fire_ok) fired_q <= 1'b1;
        st_cmp_q <= hit_cmp | (st_cmp_q & ~ctl_rd);
        st_top_q <= hit_top | (st_top_q & ~ctl_rd);
        st_any_q <= st_any_q | hit_cmp | hit_top;
      end
      if (cmp_wr) cmp_q <= wdata;
    end
  end

  assign count_o = count_q;
  assign cmp_o   = cmp_q;
  assign ctl_o   = pack_ctl(ctl_q, st_any_q, st_cmp_q, st_top_q);
  assign irq_o   = irq_q;

  // R8: control write restarts the count
  p_ctl_wr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (count_o == '0));

  // R9: compare write does not disturb an idle count
  p_cmp_wr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !tick_en) |=> $stable(count_o));

  // R2: fold lands on zero
  p_fold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmp && ctl_q[B_FOLD]) |=> (count_o == '0));

  // R5: one-shot channel that fired stays silent
  p_oneshot_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !ctl_q[B_REPEAT] && !ctl_wr) |=> !irq_o);

  // R6: read with no event clears the flags
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !hit_cmp && !hit_top) |=> (!ctl_o[11] && !ctl_o[12]));

  generate
    if (CH_IDX == 2) begin : g_halt_chk
      // R11: stop bit freezes the count
      p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_HALT] && !count_wr && !ctl_wr) |=> $stable(count_o));
    end
  endgenerate
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_tick,
  input  logic              hsync_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_chan,
  input  logic [1:0]        reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [N_CH-1:0]   irq_out
);
  logic div_tick;
  logic [N_CH-1:0] ext_vec;
  cnt_t wword;
  cnt_t        cnt_a [N_CH];
  cnt_t        cmp_a [N_CH];
  logic [15:0] ctl_a [N_CH];

  assign ext_vec = {1'b0, hsync_tick, pix_tick};
  assign wword   = trunc_word(reg_wdata);

  tmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(div_tick)
  );

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic hit_me;
      assign hit_me = (reg_chan == 2'(g));
      tmr_channel #(.CH_IDX(g)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_tick (ext_vec[g]),
        .div_tick (div_tick),
        .count_wr (reg_wr && hit_me && reg_sel == SEL_COUNT),
        .ctl_wr   (reg_wr && hit_me && reg_sel == SEL_CTL),
        .cmp_wr   (reg_wr && hit_me && reg_sel == SEL_CMP),
        .ctl_rd   (reg_rd && hit_me && reg_sel == SEL_CTL),
        .wdata    (wword),
        .count_o  (cnt_a[g]),
        .cmp_o    (cmp_a[g]),
        .ctl_o    (ctl_a[g]),
        .irq_o    (irq_out[g])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (reg_chan == 2'(k)) begin
        case (reg_sel)
          SEL_COUNT: reg_rdata = cnt_a[k];
          SEL_CTL:   reg_rdata = ctl_a[k];
          SEL_CMP:   reg_rdata = cmp_a[k];
          default:   reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, pix_tick = 0, hsync_tick = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_chan = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [2:0] irq_out;

  int n_chk = 0, n_bad = 0;
  int irq_cnt [3];
  logic done = 0;

  tmr_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    for (int k = 0; k < 3; k++) if (irq_out[k]) irq_cnt[k]++;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_chan = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic peek(input int ch, input int sel, output int v);
    @(negedge clk);
    reg_chan = 2'(ch); reg_sel = 2'(sel);
    #1 v = reg_rdata;
  endtask

  task automatic rdctl(input int ch, output int v);
    @(negedge clk);
    reg_chan = 2'(ch); reg_sel = 2'd1; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pix(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pix_tick = 1;
      @(negedge clk) pix_tick = 0;
    end
  endtask

  task automatic hs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) hsync_tick = 1;
      @(negedge clk) hsync_tick = 0;
    end
  endtask

  task automatic clr_irq();
    @(negedge clk);
    #2;
    for (int k = 0; k < 3; k++) irq_cnt[k] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, a, b, ctl, exp_p;
    for (int k = 0; k < 3; k++) irq_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state, register map (R13)
    for (int c = 0; c < 3; c++) begin
      peek(c, 1, v); chk("R13 reset ctl", v, 0);
      peek(c, 2, v); chk("R13 reset cmp", v, 0);
      peek(c, 3, v); chk("R13 select 3", v, 0);
    end
    peek(3, 0, v); chk("R13 channel 3", v, 0);
    chk("R12 reset irq", int'(irq_out), 0);

    // R1 truncation, R11 halt, R9 compare write
    wr(2, 1, 32'h0001);
    wr(2, 0, 32'h0001_2345);
    peek(2, 0, v); chk("R1 truncated count", v, 16'h2345);
    repeat (10) @(posedge clk);
    peek(2, 0, v); chk("R11 halted count", v, 16'h2345);
    wr(2, 2, 32'hABCD);
    peek(2, 0, v); chk("R9 count kept", v, 16'h2345);
    peek(2, 2, v); chk("R9 compare stored", v, 16'hABCD);
    rdctl(2, v); chk("R13 ctl readback", v, 16'h0001);

    // sweep: compare value x repeat x strobe count (R2 R4 R5 R6 R7 R12)
    for (int t = 1; t <= 4; t++)
      for (int rep = 0; rep < 2; rep++)
        for (int kk = 1; kk <= 9; kk++) begin
          ctl = rep ? 16'h0158 : 16'h0118;
          wr(0, 2, t);
          wr(0, 1, ctl);
          clr_irq();
          pix(kk);
          @(negedge clk);
          exp_p = rep ? kk / t : (kk >= t ? 1 : 0);
          chk(rep ? "R5 repeat pulses" : "R5 one-shot pulses", irq_cnt[0], exp_p);
          chk("R12 other lines quiet", irq_cnt[1] + irq_cnt[2], 0);
          peek(0, 0, v); chk("R2 folded count", v, kk % t);
          rdctl(0, v); chk("R6 flags set", v, ctl | (kk >= t ? 16'h0C00 : 0));
          rdctl(0, v); chk("R7 bit10 survives read", v, ctl | (kk >= t ? 16'h0400 : 0));
        end

    // R5 re-arm by control write
    wr(0, 2, 3);
    wr(0, 1, 16'h0118);
    clr_irq();
    pix(7);
    wr(0, 1, 16'h0118);
    pix(3);
    @(negedge clk);
    chk("R5 re-armed pulses", irq_cnt[0], 2);

    // R12 merged events at 0xFFFF with fold
    wr(0, 2, 16'hFFFF);
    wr(0, 1, 16'h0178);
    wr(0, 0, 16'hFFFD);
    clr_irq();
    pix(1);
    peek(0, 0, v); chk("R12 pre-step count", v, 16'hFFFE);
    chk("R12 no pulse yet", irq_cnt[0], 0);
    pix(1);
    @(negedge clk);
    chk("R12 single merged pulse", irq_cnt[0], 1);
    peek(0, 0, v); chk("R2 fold at FFFF", v, 0);
    rdctl(0, v); chk("R6 both flags", v, 16'h1D78);

    // R3 R4 free run past compare, wrap
    wr(0, 2, 5);
    wr(0, 1, 16'h0160);
    wr(0, 0, 3);
    clr_irq();
    pix(4);
    @(negedge clk);
    peek(0, 0, v); chk("R3 run past compare", v, 7);
    chk("R4 compare irq disabled", irq_cnt[0], 0);
    rdctl(0, v); chk("R4 flag without irq", v, 16'h0D60);
    wr(0, 0, 16'hFFFE);
    pix(1);
    peek(0, 0, v); chk("R3 reach FFFF", v, 16'hFFFF);
    pix(1);
    @(negedge clk);
    peek(0, 0, v); chk("R3 wrap to zero", v, 0);
    chk("R4 top irq pulses", irq_cnt[0], 1);
    rdctl(0, v); chk("R6 R7 top flag", v, 16'h1560);

    // R8 control write clears count and flags
    wr(0, 0, 16'h0077);
    wr(0, 1, 16'h0100);
    peek(0, 0, v); chk("R8 count zeroed", v, 0);
    rdctl(0, v); chk("R8 flags cleared", v, 16'h0100);

    // R10 strobe routing, irq mapping
    wr(1, 2, 3);
    wr(1, 1, 16'h0158);
    clr_irq();
    hs(6);
    pix(5);
    @(negedge clk);
    peek(1, 0, v); chk("R10 line strobe count", v, 0);
    peek(0, 0, v); chk("R10 pixel strobe count", v, 5);
    chk("R12 channel 1 line pulses", irq_cnt[1], 2);
    chk("R12 channel 0 line quiet", irq_cnt[0], 0);

    // R10 core clock rate
    wr(1, 1, 16'h0000);
    peek(1, 0, a);
    repeat (20) @(posedge clk);
    peek(1, 0, b);
    chk("R10 clock rate", b - a, 20);

    // R11 divided rate and stop
    wr(2, 1, 16'h0200);
    peek(2, 0, a);
    repeat (64) @(posedge clk);
    peek(2, 0, b);
    chk("R11 divide by 8", b - a, 8);
    wr(2, 1, 16'h0201);
    wr(2, 0, 16'h0010);
    peek(2, 0, a);
    repeat (64) @(posedge clk);
    peek(2, 0, b);
    chk("R11 stop bit", b, 16'h0010);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule